// File: doc/BRIEF.md
# Prioritised Interrupt Pending and Enable Controller

This block gathers one level-sensitive request line from each of up to 48 peripherals and a separate non-maskable request. Every numbered line keeps a pending bit, an enable bit and a small priority field. Each cycle the block selects the most urgent line that is both pending and enabled. It presents that line's number, with a valid flag, to the processor side. A latched non-maskable request takes precedence over every numbered line and cannot be masked.

Software reaches the state through one write port. A kind code picks the operation and an index picks the word. Pending and enable bits each have a set register and a clear register, and both use write-one semantics over banks of 32 lines. Priority fields sit four to a 32-bit word. The processor side returns an acknowledge that retires whatever is presented at that moment.

The presentation is held in a three-state machine. PS_IDLE means nothing is presented. PS_LINE presents a numbered line. PS_NMI presents the non-maskable request. Every cycle the machine takes exactly one transition, chosen by the state that will hold after the current edge:
- **to_nmi**: taken from any state when the non-maskable pending bit will be set.
- **to_line**: taken from any state when no non-maskable request is pending but some numbered line is a candidate.
- **to_idle**: taken otherwise.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, all pending bits, enable bits and priority fields are 0. After reset, `irq_valid`, `irq_nmi` and `irq_id` are 0.
- R2: A high `irq_req[i]` sampled at a clock edge sets pending bit i. The outputs after each edge reflect the pending, enable and priority state as updated at that same edge.
- R3: A write with kind 0 sets, and kind 1 clears, the pending bit of line 32*index+b for every bit b of `wr_data` that is 1. Bits that are 0 leave their lines unchanged.
- R4: A write with kind 2 sets, and kind 3 clears, enable bits, using the same bank layout as R3. A pending line whose enable bit is 0 is never presented, but it stays pending and is presented once it is enabled.
- R5: A write with kind 4 and index w loads the priority field of line 4*w+k from bits [8k+1:8k] of `wr_data`, for k from 0 to 3. Bits [8k+7:8k+2] of `wr_data` are ignored.
- R6: Among lines that are pending and enabled, the one with the smallest priority value is presented. When priority values are equal, the lowest line number is presented.
- R7: A high `nmi_req` latches a non-maskable pending bit. While that bit is set, the outputs show `irq_valid`=1, `irq_nmi`=1 and `irq_id`=0, whatever the state of the numbered lines.
- R8: `ack` clears the pending bit of the entry presented at that edge. A clear wins over a set at the same edge, so a request that is still held high sets the bit again one edge later.
- R9: The following have no effect: `ack` while nothing is presented, a write with a kind code of 5 to 7, and a write whose index is beyond the last bank or the last priority word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 48 | Level request from each peripheral line |
| nmi_req | input | 1 | Non-maskable request |
| wr_en | input | 1 | Software write strobe |
| wr_kind | input | 3 | Write operation code (0 set pending, 1 clear pending, 2 set enable, 3 clear enable, 4 priority word) |
| wr_index | input | 4 | Bank index for pending and enable writes, word index for priority writes |
| wr_data | input | 32 | Write data |
| ack | input | 1 | Processor acknowledge of the presented entry |
| irq_valid | output | 1 | An entry is presented |
| irq_nmi | output | 1 | The presented entry is the non-maskable request |
| irq_id | output | 6 | Number of the presented line (0 when the non-maskable request is presented) |

## Verification
The bench builds the block with its defaults: 48 lines, 2-bit priority fields, 32-bit data and four fields per priority word. With these values the second pending and enable bank is only half populated. This makes writes to an upper bank beyond line 47, and to a bank index past the last bank, reachable alongside legal ones. Twelve priority words leave indices 12 to 15 free to probe the out-of-range case. The four priority levels are few enough that random traffic produces frequent ties, so the lowest-number rule is exercised heavily.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        WK_SETPEND = 3'd0,
        WK_CLRPEND = 3'd1,
        WK_SETEN   = 3'd2,
        WK_CLREN   = 3'd3,
        WK_PRIO    = 3'd4
    } wr_kind_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_LINE = 2'd1,
        PS_NMI  = 2'd2
    } pres_state_e;

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
    import irq_pkg::*;
#(
    parameter int NUM_LINES = 48,
    parameter int PRIO_W    = 2,
    parameter int DATA_W    = 32,
    parameter int FPW       = 4,
    parameter int IDX_W     = 4,
    localparam int ID_W     = $clog2(NUM_LINES),
    localparam int LANE_W   = DATA_W / FPW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        irq_req,
    input  logic                        wr_en,
    input  logic [2:0]                  wr_kind,
    input  logic [IDX_W-1:0]            wr_index,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        ack_line_vld,
    input  logic [ID_W-1:0]             ack_line_id,
    output logic [NUM_LINES-1:0]        pend_q,
    output logic [NUM_LINES-1:0]        en_q,
    output logic [NUM_LINES*PRIO_W-1:0] prio_q,
    output logic [NUM_LINES-1:0]        pend_d,
    output logic [NUM_LINES-1:0]        en_d,
    output logic [NUM_LINES*PRIO_W-1:0] prio_d
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int BANK = i / DATA_W;
        localparam int BITP = i % DATA_W;
        localparam int WORD = i / FPW;
        localparam int LANE = i % FPW;

        logic bank_hit, word_hit, set_p, clr_p, set_e, clr_e;

        assign bank_hit = wr_en && (wr_index == IDX_W'(BANK));
        assign word_hit = wr_en && (wr_index == IDX_W'(WORD)) && (wr_kind == WK_PRIO);
        assign set_p = irq_req[i] || (bank_hit && wr_kind == WK_SETPEND && wr_data[BITP]);
        assign clr_p = (ack_line_vld && ack_line_id == ID_W'(i))
                    || (bank_hit && wr_kind == WK_CLRPEND && wr_data[BITP]);
        assign set_e = bank_hit && wr_kind == WK_SETEN && wr_data[BITP];
        assign clr_e = bank_hit && wr_kind == WK_CLREN && wr_data[BITP];

        // Clear dominates set (R8).
        assign pend_d[i] = clr_p ? 1'b0 : (set_p ? 1'b1 : pend_q[i]);
        assign en_d[i]   = clr_e ? 1'b0 : (set_e ? 1'b1 : en_q[i]);
        assign prio_d[i*PRIO_W +: PRIO_W] = word_hit ? wr_data[LANE*LANE_W +: PRIO_W]
                                                     : prio_q[i*PRIO_W +: PRIO_W];

        assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_line_vld && ack_line_id == ID_W'(i)) |=> !pend_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            prio_q <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
            prio_q <= prio_d;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_LINES = 48,
    parameter int PRIO_W    = 2,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]        cand,
    input  logic [NUM_LINES*PRIO_W-1:0] prio,
    output logic                        any,
    output logic [ID_W-1:0]             win_id
);

    logic [PRIO_W:0] best;

    // Strict less-than keeps the lowest index on a tie.
    always_comb begin
        best   = {1'b1, {PRIO_W{1'b0}}};
        any    = 1'b0;
        win_id = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && ({1'b0, prio[i*PRIO_W +: PRIO_W]} < best)) begin
                best   = {1'b0, prio[i*PRIO_W +: PRIO_W]};
                any    = 1'b1;
                win_id = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_present_fsm.sv
module irq_present_fsm
    import irq_pkg::*;
#(
    parameter int NUM_LINES = 48,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nmi_req,
    input  logic            ack,
    input  logic            line_any,
    input  logic [ID_W-1:0] line_id,
    output pres_state_e     state_q,
    output logic [ID_W-1:0] id_q
);

    pres_state_e state_d;
    logic        nmi_pend_q, nmi_pend_d;

    assign nmi_pend_d = (ack && state_q == PS_NMI) ? 1'b0 : (nmi_req || nmi_pend_q);

    always_comb begin
        state_d = PS_IDLE;
        unique case (state_q)
            PS_IDLE, PS_LINE, PS_NMI: begin
                if (nmi_pend_d)    state_d = PS_NMI;   // to_nmi
                else if (line_any) state_d = PS_LINE;  // to_line
                else               state_d = PS_IDLE;  // to_idle
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= PS_IDLE;
            nmi_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            nmi_pend_q <= nmi_pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 id_q <= '0;
        else if (state_d == PS_LINE) id_q <= line_id;
        else                        id_q <= '0;
    end

    assert_nmi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_NMI && !ack) |=> state_q == PS_NMI);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_LINES = 48,
    parameter int PRIO_W    = 2,
    parameter int DATA_W    = 32,
    parameter int FPW       = 4,
    localparam int NUM_WORDS = (NUM_LINES + FPW - 1) / FPW,
    localparam int IDX_W     = $clog2(NUM_WORDS),
    localparam int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 nmi_req,
    input  logic                 wr_en,
    input  logic [2:0]           wr_kind,
    input  logic [IDX_W-1:0]     wr_index,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 ack,
    output logic                 irq_valid,
    output logic                 irq_nmi,
    output logic [ID_W-1:0]      irq_id
);

    logic [NUM_LINES-1:0]        pend_q, en_q, pend_d, en_d;
    logic [NUM_LINES*PRIO_W-1:0] prio_q, prio_d;
    logic                        line_any, ack_line_vld;
    logic [ID_W-1:0]             line_id;
    pres_state_e                 state_q;

    assign ack_line_vld = ack && (state_q == PS_LINE);

    irq_line_bank #(
        .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .FPW(FPW), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_index(wr_index), .wr_data(wr_data),
        .ack_line_vld(ack_line_vld), .ack_line_id(irq_id),
        .pend_q(pend_q), .en_q(en_q), .prio_q(prio_q),
        .pend_d(pend_d), .en_d(en_d), .prio_d(prio_d)
    );

    irq_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
        .cand(pend_d & en_d), .prio(prio_d), .any(line_any), .win_id(line_id)
    );

    irq_present_fsm #(.NUM_LINES(NUM_LINES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .ack(ack),
        .line_any(line_any), .line_id(line_id), .state_q(state_q), .id_q(irq_id)
    );

    assign irq_valid = (state_q != PS_IDLE);
    assign irq_nmi   = (state_q == PS_NMI);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_valid);

    assert_enabled_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_nmi) |-> (pend_q[irq_id] && en_q[irq_id]));

    assert_nmi_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !(ack && irq_nmi)) |=> (irq_valid && irq_nmi && irq_id == '0));

    assert_ack_retires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_valid && !irq_nmi) |=>
        !(irq_valid && !irq_nmi && irq_id == $past(irq_id)));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_order_chk
        assert_prio_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_valid && !irq_nmi && pend_q[g] && en_q[g] && irq_id != ID_W'(g)) |->
            ((prio_q[g*PRIO_W +: PRIO_W] > prio_q[irq_id*PRIO_W +: PRIO_W]) ||
             ((prio_q[g*PRIO_W +: PRIO_W] == prio_q[irq_id*PRIO_W +: PRIO_W]) &&
              (ID_W'(g) > irq_id))));
    end

endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;

    localparam int NL = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] irq_req = '0;
    logic        nmi_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_kind = '0;
    logic [3:0]  wr_index = '0;
    logic [31:0] wr_data = '0;
    logic        ack = 1'b0;
    logic        irq_valid, irq_nmi;
    logic [5:0]  irq_id;

    int checks = 0;
    int errors = 0;

    logic [47:0] m_pend = '0;
    logic [47:0] m_en = '0;
    logic [1:0]  m_prio [NL];
    logic        m_nmi = 1'b0;
    logic        e_valid = 1'b0;
    logic        e_nmi = 1'b0;
    logic [5:0]  e_id = '0;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_index(wr_index), .wr_data(wr_data),
        .ack(ack), .irq_valid(irq_valid), .irq_nmi(irq_nmi), .irq_id(irq_id)
    );

    always #2 clk = ~clk;

    function automatic void compare(input string tag);
        checks++;
        if ({irq_valid, irq_nmi, irq_id} !== {e_valid, e_nmi, e_id}) begin
            errors++;
            $display("FAIL %s: got valid=%0b nmi=%0b id=%0d, expected valid=%0b nmi=%0b id=%0d",
                     tag, irq_valid, irq_nmi, irq_id, e_valid, e_nmi, e_id);
        end
    endfunction

    function automatic void pick_winner();
        logic [2:0] best = 3'd4;
        e_valid = 1'b0; e_nmi = 1'b0; e_id = '0;
        if (m_nmi) begin
            e_valid = 1'b1; e_nmi = 1'b1;
        end else begin
            for (int i = 0; i < NL; i++)
                if (m_pend[i] && m_en[i] && {1'b0, m_prio[i]} < best) begin
                    best = {1'b0, m_prio[i]};
                    e_valid = 1'b1;
                    e_id = 6'(i);
                end
        end
    endfunction

    task automatic step(input logic [47:0] rq, input logic nm, input logic we,
                        input logic [2:0] kd, input logic [3:0] ix,
                        input logic [31:0] dt, input logic ak, input string tag);
        logic [47:0] np, ne;
        @(negedge clk);
        irq_req = rq; nmi_req = nm; wr_en = we; wr_kind = kd;
        wr_index = ix; wr_data = dt; ack = ak;
        for (int i = 0; i < NL; i++) begin
            logic hit, sp, cp;
            hit = we && (ix == 4'(i / 32));
            sp = rq[i] || (hit && kd == 3'd0 && dt[i % 32]);
            cp = (ak && e_valid && !e_nmi && e_id == 6'(i)) || (hit && kd == 3'd1 && dt[i % 32]);
            np[i] = cp ? 1'b0 : (sp ? 1'b1 : m_pend[i]);
            ne[i] = (hit && kd == 3'd3 && dt[i % 32]) ? 1'b0
                  : ((hit && kd == 3'd2 && dt[i % 32]) ? 1'b1 : m_en[i]);
            if (we && kd == 3'd4 && ix < 4'd12 && (i / 4) == int'(ix))
                m_prio[i] = dt[(i % 4) * 8 +: 2];
        end
        m_nmi = (ak && e_nmi) ? 1'b0 : (nm || m_nmi);
        m_pend = np; m_en = ne;
        pick_winner();
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    function automatic logic [47:0] ln(input int n);
        return 48'(1) << n;
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NL; i++) m_prio[i] = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset state");

        step(ln(5), 0, 0, 0, 0, 0, 0, "R4 disabled line not shown");
        step(0, 0, 1, 3'd2, 0, 32'h20, 0, "R4 enable shows pending line");
        step(0, 0, 1, 3'd3, 0, 32'h20, 0, "R4 clear enable hides line");
        step(0, 0, 1, 3'd2, 0, 32'h20, 0, "R4 re-enable keeps pending");
        step(0, 0, 1, 3'd2, 1, 32'h100, 0, "R1 enable line 40 default prio");
        step(ln(40), 0, 0, 0, 0, 0, 0, "R6 tie lowest number wins");
        step(0, 0, 1, 3'd4, 1, 32'h0000_FD00, 0, "R5 lane field with upper bits");
        step(0, 0, 0, 0, 0, 0, 1, "R8 ack retires line 40");
        step(ln(5), 0, 0, 0, 0, 0, 1, "R8 clear wins over held request");
        step(ln(5), 0, 0, 0, 0, 0, 0, "R8 held request sets again");
        step(0, 1, 0, 0, 0, 0, 0, "R7 nmi presented");
        step(0, 0, 1, 3'd2, 0, 32'hFFFF_FFFF, 0, "R7 nmi not masked by lines");
        step(0, 0, 0, 0, 0, 0, 1, "R7 ack nmi returns to line");
        step(0, 0, 1, 3'd1, 0, 32'h20, 0, "R3 clear pending");
        step(0, 0, 0, 0, 0, 0, 1, "R9 ack while idle");
        step(0, 0, 1, 3'd0, 1, 32'h100, 0, "R3 set pending upper bank");
        step(0, 0, 1, 3'd7, 0, 32'hFFFF_FFFF, 0, "R9 bad kind ignored");
        step(0, 0, 1, 3'd5, 1, 32'hFFFF_FFFF, 0, "R9 kind 5 ignored");
        step(0, 0, 1, 3'd1, 3, 32'hFFFF_FFFF, 0, "R9 bank index out of range");
        step(0, 0, 1, 3'd4, 4'd13, 32'h0303_0303, 0, "R9 prio index out of range");
        step(0, 0, 1, 3'd0, 0, 32'h0000_000C, 0, "R2 mixed pending");
        step(0, 0, 1, 3'd4, 0, 32'h0000_0200, 0, "R5 word 0 lane 1 sets line 1");

        for (int c = 0; c < 3000; c++) begin
            logic [47:0] rq;
            logic        we;
            rq = 48'({$urandom(), $urandom()} & {$urandom(), $urandom()} &
                     {$urandom(), $urandom()} & {$urandom(), $urandom()});
            if ((c % 4) != 0) rq = '0;
            we = ($urandom() % 3) == 0;
            step(rq, ($urandom() % 64) == 0, we, 3'($urandom()), 4'($urandom()),
                 $urandom(), $urandom() % 2 == 0, "R2 R6 random traffic");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule